// File: doc/BRIEF.md
# Dual-Rate Programmable Interval Timer

A 32-bit down-counting interval timer with four word registers on a simple synchronous bus: a load value, the live count, a control word and a write-only interrupt clear. The count advances only on cycles where the selected tick-enable input is high. A control bit chooses between a slow tick and a fast tick. Both ticks come from outside the block and are single-cycle enables in the bus clock domain.

When the count steps from 1, the timer raises a level interrupt. In periodic mode the count then refills from the load register. In one-shot mode it rests at zero until software writes a new load value. A write to the load register also places that value into the live count at once, even while the timer is running, so software can restart an interval at any moment.

The bus address is a word index: index 0 is byte offset 0x0, 1 is 0x4, 2 is 0x8 and 3 is 0xC. Read data is registered. It presents the addressed register one clock after the address, reflecting the state before that clock edge.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset the load value, count, control word and interrupt are all zero, and every register reads as zero.
- R2: A write to index 0 stores the data as the load value and sets the live count to the same value at that clock edge. This holds whether or not the timer is enabled, and it takes priority over any tick in the same cycle.
- R3: With control bit 0 (run) clear, the count holds its value whatever the ticks do.
- R4: Control bit 3 selects the tick: 0 uses `slow_tick`, 1 uses `fast_tick`. The tick that is not selected has no effect on the count.
- R5: With control bit 1 set (periodic), a selected tick while running at count 1 refills the count from the load value and sets the interrupt.
- R6: With control bit 1 clear (one-shot), a selected tick while running at count 1 sets the count to 0 and sets the interrupt. A count of 0 then stays 0 until index 0 is written.
- R7: The interrupt is a level that stays high until any write to index 3, whatever the data. If an expiry and a clear write fall in the same cycle, the interrupt stays high.
- R8: Reading index 2 returns run in bit 0, periodic in bit 1 and tick select in bit 3. Bit 2 and bits 31..4 read as zero whatever was written.
- R9: Reading index 3 returns zero, and a write to index 1 changes neither the count nor any other register.
- R10: `bus_rdata` shows the register addressed in one cycle on the following cycle, and it shows the value that register held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word index of the register (0 load, 1 count, 2 control, 3 clear) |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| slow_tick | input | 1 | Slow count enable, one cycle per tick |
| fast_tick | input | 1 | Fast count enable, one cycle per tick |
| irq | output | 1 | Level interrupt, high while an expiry is pending |

## Verification
On every cycle, the assertions check several relations. A load write lands in the count on the next edge. The count holds while stopped. A zero count sticks until it is reloaded. A periodic expiry refills from the load value. Any expiry raises the interrupt, and the interrupt is released only by a clear write. Other behaviours can only be shown by the bench's scenarios, which it compares against a behavioural model on every clock: which tick source drives the count, the packing of the control read-back, the zero read of the clear register, the ignored write to the count register, and the one-cycle read latency.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int REG_IDX_W = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_LOAD  = 2'd0,
    IDX_COUNT = 2'd1,
    IDX_CTRL  = 2'd2,
    IDX_CLEAR = 2'd3
  } reg_idx_e;

  localparam int BIT_RUN      = 0;
  localparam int BIT_PERIODIC = 1;
  localparam int BIT_FAST     = 3;

  typedef struct packed {
    logic fast_sel;
    logic periodic;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  reg_idx_e          idx,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_val,
  output ctrl_t             ctrl,
  output logic              load_wr,
  output logic              clr_wr
);
  assign load_wr = we && (idx == IDX_LOAD);
  assign clr_wr  = we && (idx == IDX_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_val <= '0;
      ctrl     <= '0;
    end else begin
      if (load_wr) load_val <= wdata;
      if (we && idx == IDX_CTRL) begin
        ctrl.run      <= wdata[BIT_RUN];
        ctrl.periodic <= wdata[BIT_PERIODIC];
        ctrl.fast_sel <= wdata[BIT_FAST];
      end
    end
  end

  a_r2_load_stored: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> load_val == $past(wdata));
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              tick,
  input  logic              run,
  input  logic              periodic,
  output logic [DATA_W-1:0] count,
  output logic              expire
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic step;
  assign step   = !load_wr && run && tick && (count != '0);
  assign expire = step && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (load_wr) count <= load_data;
    else if (expire)  count <= periodic ? reload_val : '0;
    else if (step)    count <= count - ONE;
  end

  a_r2_count_loaded: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> count == $past(load_data));
  a_r3_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_wr) |=> $stable(count));
  a_r6_zero_sticks: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !load_wr) |=> count == '0);
  a_r5_periodic_refill: assert property (@(posedge clk) disable iff (rst)
    (run && tick && periodic && count == ONE && !load_wr)
      |=> count == $past(reload_val));
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  a_r7_expiry_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> irq);
  a_r7_level_held: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              slow_tick,
  input  logic              fast_tick,
  output logic              irq
);
  reg_idx_e          idx;
  logic [DATA_W-1:0] load_val, count;
  ctrl_t             ctrl;
  logic              load_wr, clr_wr, tick, expire;
  logic [DATA_W-1:0] ctrl_word, rd_next;

  assign idx  = reg_idx_e'(bus_addr);
  assign tick = ctrl.fast_sel ? fast_tick : slow_tick;

  timer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .idx(idx), .we(bus_we), .wdata(bus_wdata),
    .load_val(load_val), .ctrl(ctrl), .load_wr(load_wr), .clr_wr(clr_wr)
  );

  timer_counter #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rst(rst), .load_wr(load_wr), .load_data(bus_wdata),
    .reload_val(load_val), .tick(tick), .run(ctrl.run),
    .periodic(ctrl.periodic), .count(count), .expire(expire)
  );

  timer_irq u_irq (
    .clk(clk), .rst(rst), .set(expire), .clr(clr_wr), .irq(irq)
  );

  always_comb begin
    ctrl_word               = '0;
    ctrl_word[BIT_RUN]      = ctrl.run;
    ctrl_word[BIT_PERIODIC] = ctrl.periodic;
    ctrl_word[BIT_FAST]     = ctrl.fast_sel;
    unique case (idx)
      IDX_LOAD:  rd_next = load_val;
      IDX_COUNT: rd_next = count;
      IDX_CTRL:  rd_next = ctrl_word;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (bus_rdata == '0 && !irq));
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = 2'd1;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        slow_tick = 1'b0;
  logic        fast_tick = 1'b0;
  logic        irq;

  interval_timer dut (.*);

  always #10 clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  string phase = "R1";
  bit    done = 0;

  // behavioural model
  longint m_load, m_count, m_rdata;
  bit     m_run, m_per, m_fast, m_irq;

  task automatic chk(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    longint rd, cnt;
    bit tk, ex, clr;
    if (rst) begin
      m_load = 0; m_count = 0; m_rdata = 0;
      m_run = 0; m_per = 0; m_fast = 0; m_irq = 0;
    end else begin
      case (bus_addr)
        2'd0: rd = m_load;
        2'd1: rd = m_count;
        2'd2: rd = {m_fast, 1'b0, m_per, m_run};
        default: rd = 0;
      endcase
      tk = m_fast ? fast_tick : slow_tick;
      ex = 0;
      cnt = m_count;
      clr = bus_we && bus_addr == 2'd3;
      if (bus_we && bus_addr == 2'd0) cnt = bus_wdata;
      else if (m_run && tk && m_count != 0) begin
        if (m_count == 1) begin
          ex = 1;
          cnt = m_per ? m_load : 0;
        end else cnt = m_count - 1;
      end
      if (bus_we && bus_addr == 2'd0) m_load = bus_wdata;
      if (bus_we && bus_addr == 2'd2) begin
        m_run = bus_wdata[0]; m_per = bus_wdata[1]; m_fast = bus_wdata[3];
      end
      if (ex) m_irq = 1; else if (clr) m_irq = 0;
      m_count = cnt;
      m_rdata = rd;
    end
    #5;
    if (!done) begin
      chk({phase, " rdata"}, bus_rdata, m_rdata);
      chk({phase, " irq"}, irq, m_irq);
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd1;
  endtask

  task automatic rd_at(logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    bus_addr = 2'd1;
  endtask

  task automatic ticks(int n, bit s, bit f);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slow_tick = s; fast_tick = f;
    end
    @(negedge clk);
    slow_tick = 0; fast_tick = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state on every register
    for (int a = 0; a < 4; a++) begin
      rd_at(2'(a), v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 irq", irq, 0);

    phase = "R2";
    wr(2'd0, 32'd5);
    rd_at(2'd1, v); chk("R2 count loaded", v, 5);
    rd_at(2'd0, v); chk("R2 load stored", v, 5);

    phase = "R8";
    wr(2'd2, 32'hFFFF_FFFF);
    rd_at(2'd2, v); chk("R8 ctrl packing", v, 32'hB);

    phase = "R3";
    wr(2'd2, 32'h2);  // stopped, periodic
    ticks(4, 1, 1);
    rd_at(2'd1, v); chk("R3 stopped holds", v, 5);

    phase = "R4";
    wr(2'd2, 32'h3);  // run, periodic, slow
    ticks(3, 0, 1);
    rd_at(2'd1, v); chk("R4 fast ignored on slow", v, 5);
    ticks(2, 1, 0);
    rd_at(2'd1, v); chk("R4 slow counts", v, 3);

    phase = "R5";
    ticks(3, 1, 0);
    chk("R5 irq raised", irq, 1);
    rd_at(2'd1, v); chk("R5 refilled", v, 5);

    phase = "R7";
    ticks(2, 1, 0);
    chk("R7 level held", irq, 1);
    wr(2'd3, 32'h0);
    chk("R7 cleared by write", irq, 0);
    ticks(3, 1, 0);
    chk("R7 expiry again", irq, 1);
    wr(2'd0, 32'd1);
    @(negedge clk);
    bus_addr = 2'd3; bus_we = 1'b1; slow_tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; slow_tick = 1'b0; bus_addr = 2'd1;
    chk("R7 expiry beats clear", irq, 1);
    wr(2'd3, 32'hDEAD_BEEF);

    phase = "R6";
    wr(2'd2, 32'h9);  // run, one-shot, fast
    wr(2'd0, 32'd3);
    ticks(3, 0, 1);
    chk("R6 irq", irq, 1);
    ticks(4, 0, 1);
    rd_at(2'd1, v); chk("R6 rests at zero", v, 0);

    phase = "R2";
    wr(2'd0, 32'd40);
    ticks(10, 0, 1);
    wr(2'd0, 32'd7);
    rd_at(2'd1, v); chk("R2 reload while running", v, 7);

    phase = "R9";
    wr(2'd1, 32'h1234);
    rd_at(2'd1, v); chk("R9 count write ignored", v, 7);
    rd_at(2'd0, v); chk("R9 load untouched", v, 7);
    rd_at(2'd3, v); chk("R9 clear reads zero", v, 0);

    phase = "R10";
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      bus_addr = 2'(i); fast_tick = i[0];
    end
    fast_tick = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule